// File: doc/BRIEF.md
# Write-Back Coherent Line Controller

This block sits between a processor's load/store port and a shared memory bus. It tracks the coherence status of every line of a small direct-mapped write-back cache, holds the line data in a register array, and decides per request whether it can finish locally or whether a bus transaction must come first. Each line carries one of four states: Invalid, Shared, Exclusive or Modified.

Loads and stores on lines held Exclusive or Modified complete in the cycle they are presented. A store to a Shared line first wins the bus and runs an invalidate-only (kill) transaction for the line's start address; the write lands only when that finishes. A store miss fetches the line with a read-for-ownership, merges the store into the fill and marks the line Modified. A load miss runs a plain read and installs the line Shared or Exclusive according to the shared indication returned with the fill. A Modified victim is written back as a full line before the new line is requested. Snoop handling lives elsewhere; the per-line states are exported on `line_state` for it.

The controller runs three states. IDLE answers hits and, on a request that needs the bus, loads the first command and moves to ARB. ARB raises `bus_req` and moves to XFER on `bus_gnt`. XFER waits for `bus_done`: after a write-back it loads the fill command and returns to ARB, after any other command it completes the request and returns to IDLE.

Top module: `wb_line_ctrl`

## Requirements
- R1: `line_state` holds two bits per line, line i at bits [2i+1:2i], coded Invalid=0, Shared=1, Exclusive=2, Modified=3; after reset every line is Invalid, `bus_req` is low and `cpu_ready` is high.
- R2: A load that hits returns the addressed word on `cpu_rdata` with `cpu_ready` high in the same cycle, issues no bus command and leaves the line state unchanged.
- R3: A store that hits an Exclusive line completes with no bus command and leaves the line Modified.
- R4: A store that hits a Modified line updates the data, completes with no bus command and the line stays Modified.
- R5: A store that hits a Shared line first issues a kill (`bus_cmd`=2) whose `bus_addr` is the line's start address (offset bits zero); only after `bus_done` is the data written and the line Modified.
- R6: A store miss issues a read-for-ownership (`bus_cmd`=1); on `bus_done` the store is merged into the fill and the line becomes Modified.
- R7: A load miss issues a plain read (`bus_cmd`=0); the line is installed Shared when `bus_shared` is high at `bus_done`, else Exclusive, and the requested word of the fill is returned.
- R8: A miss that displaces a Modified line first issues a write-back (`bus_cmd`=3) carrying the victim's start address and full line on `bus_wdata`, and only then the fill; a clean victim is dropped without a write-back.
- R9: While a bus transaction is in progress `cpu_ready` is low; `bus_req` stays high with `bus_cmd` and `bus_addr` unchanged until `bus_gnt`.
- R10: A store changes only the byte lanes whose `cpu_be` bit is set (bit k covers data bits [8k+7:8k]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request valid, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address: tag, index, word offset (low bits) |
| cpu_be | input | WORD_W/8 | Store byte enables |
| cpu_wdata | input | WORD_W | Store data |
| cpu_ready | output | 1 | Request completes at this clock edge |
| cpu_rdata | output | WORD_W | Load data, valid with cpu_ready |
| bus_req | output | 1 | Bus request, held until grant |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 kill, 3 write-back |
| bus_addr | output | ADDR_W | Line start word address |
| bus_wdata | output | LINE_WORDS*WORD_W | Full line for write-back |
| bus_done | input | 1 | Transaction complete, fill data valid |
| bus_rdata | input | LINE_WORDS*WORD_W | Fill line |
| bus_shared | input | 1 | Another cache holds the line (reads) |
| line_state | output | 2*NUM_LINES | Per-line coherence state for the snooper |

## Verification
The bound checker watches every cycle that the processor side is stalled while the bus is requested, that requests hold their command and line-aligned address until granted, that kills and ownership reads end with the line Modified, that a plain read installs Shared or Exclusive per `bus_shared`, that no fill is requested over a dirty line, and that local stores on Exclusive or Modified lines complete at once. Data correctness — byte-lane merging, the write-back payload, fill contents and the exact ordering and count of bus commands per request — is only visible in the bench's scenarios, which replay directed corner cases and a seeded random mix against a reference cache and memory model.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        BC_READ  = 2'd0,
        BC_RWITM = 2'd1,
        BC_KILL  = 2'd2,
        BC_WBACK = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_ARB  = 2'd1,
        FS_XFER = 2'd2
    } fsm_st_t;

endpackage

// File: rtl/wbc_store.sv
module wbc_store
    import wbc_pkg::*;
#(
    parameter int NUM_LINES  = 4,
    parameter int LINE_WORDS = 4,
    parameter int WORD_W     = 32,
    parameter int TAG_W      = 6,
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int BE_W      = WORD_W / 8,
    localparam int LINE_W    = WORD_W * LINE_WORDS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       rd_idx,
    input  logic                   upd_en,
    input  line_st_t               upd_state,
    input  logic                   upd_tag_en,
    input  logic [TAG_W-1:0]       upd_tag,
    input  logic                   fill_en,
    input  logic [LINE_W-1:0]      fill_data,
    input  logic                   wr_en,
    input  logic [OFF_W-1:0]       wr_off,
    input  logic [BE_W-1:0]        wr_be,
    input  logic [WORD_W-1:0]      wr_data,
    output logic [TAG_W-1:0]       rd_tag,
    output line_st_t               rd_state,
    output logic [LINE_W-1:0]      rd_line,
    output logic [2*NUM_LINES-1:0] state_vec
);

    line_st_t         st_q  [NUM_LINES];
    logic [TAG_W-1:0] tag_q [NUM_LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                st_q[l]  <= LS_I;
                tag_q[l] <= '0;
            end
        end else begin
            if (upd_en)     st_q[rd_idx]  <= upd_state;
            if (upd_tag_en) tag_q[rd_idx] <= upd_tag;
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_state = st_q[rd_idx];

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_vec
        assign state_vec[2*l +: 2] = st_q[l];
    end

    // One storage column per word offset; fill and byte merge share a write port.
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_col
        logic [WORD_W-1:0] col_q [NUM_LINES];
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] nx;
        logic              hit_word;
        logic              we;

        assign hit_word = wr_en && (wr_off == OFF_W'(w));
        assign we       = fill_en || hit_word;
        assign base     = fill_en ? fill_data[w*WORD_W +: WORD_W] : col_q[rd_idx];

        always_comb begin
            nx = base;
            if (hit_word) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (wr_be[b]) nx[b*8 +: 8] = wr_data[b*8 +: 8];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (we) col_q[rd_idx] <= nx;
        end

        assign rd_line[w*WORD_W +: WORD_W] = col_q[rd_idx];
    end

endmodule

// File: rtl/wbc_fsm.sv
module wbc_fsm
    import wbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cpu_req,
    input  logic     cpu_we,
    input  logic     hit,
    input  line_st_t line_st,
    input  logic     bus_gnt,
    input  logic     bus_done,
    output logic     cpu_ready,
    output logic     bus_req,
    output bus_cmd_t bus_cmd,
    output logic     do_local_store,
    output logic     do_kill_done,
    output logic     do_fill_done,
    output logic     do_wb_done
);

    fsm_st_t  state_q, state_d;
    bus_cmd_t cmd_q, cmd_d;
    logic     need_bus;
    bus_cmd_t first_cmd;
    bus_cmd_t fill_cmd;

    assign need_bus  = !hit || (cpu_we && line_st == LS_S);
    assign fill_cmd  = cpu_we ? BC_RWITM : BC_READ;
    assign first_cmd = hit ? BC_KILL : ((line_st == LS_M) ? BC_WBACK : fill_cmd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            cmd_q   <= BC_READ;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cmd_d   = cmd_q;
        unique case (state_q)
            FS_IDLE: begin
                if (cpu_req && need_bus) begin
                    state_d = FS_ARB;
                    cmd_d   = first_cmd;
                end
            end
            FS_ARB: begin
                if (bus_gnt) state_d = FS_XFER;
            end
            FS_XFER: begin
                if (bus_done) begin
                    if (cmd_q == BC_WBACK) begin
                        state_d = FS_ARB;
                        cmd_d   = fill_cmd;
                    end else begin
                        state_d = FS_IDLE;
                    end
                end
            end
            default: state_d = FS_IDLE;
        endcase
    end

    always_comb begin
        cpu_ready      = 1'b0;
        bus_req        = 1'b0;
        do_local_store = 1'b0;
        do_kill_done   = 1'b0;
        do_fill_done   = 1'b0;
        do_wb_done     = 1'b0;
        bus_cmd        = cmd_q;
        unique case (state_q)
            FS_IDLE: begin
                cpu_ready      = !(cpu_req && need_bus);
                do_local_store = cpu_req && cpu_we && hit
                                 && (line_st == LS_E || line_st == LS_M);
            end
            FS_ARB: begin
                bus_req = 1'b1;
            end
            FS_XFER: begin
                if (bus_done) begin
                    unique case (cmd_q)
                        BC_WBACK: do_wb_done = 1'b1;
                        BC_KILL: begin
                            do_kill_done = 1'b1;
                            cpu_ready    = 1'b1;
                        end
                        BC_READ, BC_RWITM: begin
                            do_fill_done = 1'b1;
                            cpu_ready    = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wb_line_ctrl.sv
module wb_line_ctrl
    import wbc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NUM_LINES  = 4,
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
    localparam int BE_W      = WORD_W / 8,
    localparam int LINE_W    = WORD_W * LINE_WORDS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_req,
    input  logic                   cpu_we,
    input  logic [ADDR_W-1:0]      cpu_addr,
    input  logic [BE_W-1:0]        cpu_be,
    input  logic [WORD_W-1:0]      cpu_wdata,
    output logic                   cpu_ready,
    output logic [WORD_W-1:0]      cpu_rdata,
    output logic                   bus_req,
    input  logic                   bus_gnt,
    output logic [1:0]             bus_cmd,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [LINE_W-1:0]      bus_wdata,
    input  logic                   bus_done,
    input  logic [LINE_W-1:0]      bus_rdata,
    input  logic                   bus_shared,
    output logic [2*NUM_LINES-1:0] line_state
);

    logic [OFF_W-1:0]  req_off;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [TAG_W-1:0]  rd_tag;
    line_st_t          rd_state;
    logic [LINE_W-1:0] rd_line;
    logic              hit;
    bus_cmd_t          cmd;
    logic              do_local_store, do_kill_done, do_fill_done, do_wb_done;
    logic              upd_en;
    line_st_t          upd_state;
    logic              wr_en;

    assign req_off = cpu_addr[OFF_W-1:0];
    assign req_idx = cpu_addr[OFF_W +: IDX_W];
    assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign hit     = (rd_state != LS_I) && (rd_tag == req_tag);

    wbc_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req        (cpu_req),
        .cpu_we         (cpu_we),
        .hit            (hit),
        .line_st        (rd_state),
        .bus_gnt        (bus_gnt),
        .bus_done       (bus_done),
        .cpu_ready      (cpu_ready),
        .bus_req        (bus_req),
        .bus_cmd        (cmd),
        .do_local_store (do_local_store),
        .do_kill_done   (do_kill_done),
        .do_fill_done   (do_fill_done),
        .do_wb_done     (do_wb_done)
    );

    always_comb begin
        if (do_wb_done)
            upd_state = LS_I;
        else if (do_fill_done && !cpu_we)
            upd_state = bus_shared ? LS_S : LS_E;
        else
            upd_state = LS_M;
    end

    assign upd_en = do_local_store || do_kill_done || do_fill_done || do_wb_done;
    assign wr_en  = cpu_we && (do_local_store || do_kill_done || do_fill_done);

    wbc_store #(
        .NUM_LINES  (NUM_LINES),
        .LINE_WORDS (LINE_WORDS),
        .WORD_W     (WORD_W),
        .TAG_W      (TAG_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (req_idx),
        .upd_en     (upd_en),
        .upd_state  (upd_state),
        .upd_tag_en (do_fill_done),
        .upd_tag    (req_tag),
        .fill_en    (do_fill_done),
        .fill_data  (bus_rdata),
        .wr_en      (wr_en),
        .wr_off     (req_off),
        .wr_be      (cpu_be),
        .wr_data    (cpu_wdata),
        .rd_tag     (rd_tag),
        .rd_state   (rd_state),
        .rd_line    (rd_line),
        .state_vec  (line_state)
    );

    assign bus_cmd   = cmd;
    assign bus_addr  = (cmd == BC_WBACK) ? {rd_tag, req_idx, {OFF_W{1'b0}}}
                                         : {req_tag, req_idx, {OFF_W{1'b0}}};
    assign bus_wdata = rd_line;
    assign cpu_rdata = do_fill_done ? bus_rdata[req_off*WORD_W +: WORD_W]
                                    : rd_line[req_off*WORD_W +: WORD_W];

endmodule

// File: rtl/wbc_chk.sv
module wbc_chk #(
    parameter int ADDR_W     = 10,
    parameter int LINE_WORDS = 4,
    parameter int NUM_LINES  = 4,
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int IDX_W     = $clog2(NUM_LINES)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cpu_req,
    input logic                   cpu_we,
    input logic [ADDR_W-1:0]      cpu_addr,
    input logic                   cpu_ready,
    input logic                   bus_req,
    input logic                   bus_gnt,
    input logic [1:0]             bus_cmd,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_done,
    input logic                   bus_shared,
    input logic [2*NUM_LINES-1:0] line_state,
    input logic                   hit
);

    logic [IDX_W-1:0] idx, idx_q;
    logic [1:0]       st_here, st_prev_idx;
    logic             granted_q;

    assign idx         = cpu_addr[OFF_W +: IDX_W];
    assign st_here     = line_state[{idx, 1'b0} +: 2];
    assign st_prev_idx = line_state[{idx_q, 1'b0} +: 2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            granted_q <= 1'b0;
        end else begin
            idx_q <= idx;
            if (bus_done)                granted_q <= 1'b0;
            else if (bus_req && bus_gnt) granted_q <= 1'b1;
        end
    end

    a_r9_stall_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_ready);

    a_r9_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    a_r5_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr[OFF_W-1:0] == '0));

    a_r5_kill_makes_m: assert property (@(posedge clk) disable iff (!rst_n)
        (granted_q && bus_done && bus_cmd == 2'd2) |=> (st_prev_idx == 2'd3));

    a_r6_rwitm_makes_m: assert property (@(posedge clk) disable iff (!rst_n)
        (granted_q && bus_done && bus_cmd == 2'd1) |=> (st_prev_idx == 2'd3));

    a_r7_read_install: assert property (@(posedge clk) disable iff (!rst_n)
        (granted_q && bus_done && bus_cmd == 2'd0)
            |=> (st_prev_idx == ($past(bus_shared) ? 2'd1 : 2'd2)));

    a_r8_no_fill_over_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && (bus_cmd == 2'd0 || bus_cmd == 2'd1)) |-> (st_here != 2'd3));

    a_r4_m_store_local: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && hit && st_here == 2'd3 && !bus_req && !granted_q)
            |-> cpu_ready);

    a_r3_e_store_to_m: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && hit && st_here == 2'd2 && !bus_req && !granted_q)
            |-> cpu_ready ##1 (st_prev_idx == 2'd3));

endmodule

bind wb_line_ctrl wbc_chk #(
    .ADDR_W     (ADDR_W),
    .LINE_WORDS (LINE_WORDS),
    .NUM_LINES  (NUM_LINES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_ready  (cpu_ready),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .bus_done   (bus_done),
    .bus_shared (bus_shared),
    .line_state (line_state),
    .hit        (hit)
);

// File: tb/tb_wb_line_ctrl.sv
module tb_wb_line_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NWORDS     = 1024;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [9:0]   cpu_addr = '0;
    logic [3:0]   cpu_be = '0;
    logic [31:0]  cpu_wdata = '0;
    logic         cpu_ready;
    logic [31:0]  cpu_rdata;
    logic         bus_req;
    logic         bus_gnt = 1'b0;
    logic [1:0]   bus_cmd;
    logic [9:0]   bus_addr;
    logic [127:0] bus_wdata;
    logic         bus_done = 1'b0;
    logic [127:0] bus_rdata = '0;
    logic         bus_shared = 1'b0;
    logic [7:0]   line_state;

    wb_line_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .bus_shared(bus_shared), .line_state(line_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, failures = 0;
    logic [31:0]  mem [NWORDS];
    logic [31:0]  mdat [4][4];
    int           mtag [4];
    logic [1:0]   mst [4];
    int           ncmd;
    logic [1:0]   cmd_log [4];
    logic [9:0]   addr_log [4];
    logic [127:0] wdat_log [4];
    int           share_mode = 0;
    logic         last_shared = 1'b0;
    bit           done_flag = 1'b0;

    task automatic chk(input bit ok, input string r, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic logic [9:0] line_addr(input int tg, input int ix);
        return 10'(tg * 16 + ix * 4);
    endfunction

    function automatic logic [7:0] model_vec();
        logic [7:0] v;
        for (int i = 0; i < 4; i++) v[2*i +: 2] = mst[i];
        return v;
    endfunction

    // Bus responder: memory side with random grant and completion delays.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req && rst_n) begin
                repeat ($urandom_range(0, 2)) @(negedge clk);
                bus_gnt = 1'b1;
                if (ncmd < 4) begin
                    cmd_log[ncmd]  = bus_cmd;
                    addr_log[ncmd] = bus_addr;
                    wdat_log[ncmd] = bus_wdata;
                end
                ncmd++;
                @(negedge clk);
                bus_gnt = 1'b0;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                if (bus_cmd == 2'd3)
                    for (int w = 0; w < 4; w++) mem[int'(bus_addr) + w] = bus_wdata[w*32 +: 32];
                for (int w = 0; w < 4; w++) bus_rdata[w*32 +: 32] = mem[int'(bus_addr) + w];
                bus_shared  = (share_mode == 2) ? 1'b1 : (share_mode == 1) ? 1'b0 : 1'($urandom % 2);
                last_shared = bus_shared;
                bus_done = 1'b1;
                @(negedge clk);
                bus_done = 1'b0;
            end
        end
    end

    task automatic do_op(input logic we, input logic [9:0] a, input logic [3:0] be,
                         input logic [31:0] wd, input int shm);
        int idx, tg, off, n_exp;
        logic hit;
        logic [1:0] vst;
        string rq;
        logic [1:0] ec [2];
        logic [9:0] ea [2];
        logic [127:0] vline;
        logic [31:0] got;
        idx = int'(a[3:2]); off = int'(a[1:0]); tg = int'(a[9:4]);
        vst = mst[idx];
        hit = (vst != 2'd0) && (mtag[idx] == tg);
        for (int w = 0; w < 4; w++) vline[w*32 +: 32] = mdat[idx][w];
        n_exp = 0;
        if (!hit) begin
            if (vst == 2'd3) begin
                ec[0] = 2'd3; ea[0] = line_addr(mtag[idx], idx); n_exp = 1;
            end
            ec[n_exp] = we ? 2'd1 : 2'd0; ea[n_exp] = line_addr(tg, idx); n_exp++;
        end else if (we && vst == 2'd1) begin
            ec[0] = 2'd2; ea[0] = line_addr(tg, idx); n_exp = 1;
        end
        if (!hit) rq = (vst == 2'd3) ? "R8" : (we ? "R6" : "R7");
        else if (!we) rq = "R2";
        else rq = (vst == 2'd1) ? "R5" : (vst == 2'd2) ? "R3" : "R4";

        share_mode = shm; ncmd = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
        end
        got = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;

        chk(ncmd == n_exp, {rq, " bus command count"}, 128'(ncmd), 128'(n_exp));
        for (int i = 0; i < n_exp && i < ncmd; i++) begin
            chk(cmd_log[i] == ec[i], {rq, " bus command"}, 128'(cmd_log[i]), 128'(ec[i]));
            chk(addr_log[i] == ea[i], {rq, " bus address"}, 128'(addr_log[i]), 128'(ea[i]));
        end
        if (!hit && vst == 2'd3 && ncmd > 0)
            chk(wdat_log[0] == vline, "R8 write-back line", wdat_log[0], vline);

        if (!hit) begin
            for (int w = 0; w < 4; w++) mdat[idx][w] = mem[int'(line_addr(tg, idx)) + w];
            mtag[idx] = tg;
            mst[idx] = we ? 2'd3 : (last_shared ? 2'd1 : 2'd2);
        end
        if (!we) begin
            chk(got == mdat[idx][off], {rq, " load data"}, 128'(got), 128'(mdat[idx][off]));
        end else begin
            for (int b = 0; b < 4; b++)
                if (be[b]) mdat[idx][off][b*8 +: 8] = wd[b*8 +: 8];
            mst[idx] = 2'd3;
        end
        chk(line_state == model_vec(), {rq, " line states"}, 128'(line_state), 128'(model_vec()));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++; failures++;
            $display("FAIL R9 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd5721);
        for (int i = 0; i < NWORDS; i++) mem[i] = 32'(i) * 32'h9E37_79B9 ^ 32'h5A5A_0F0F;
        for (int i = 0; i < 4; i++) begin
            mtag[i] = 0; mst[i] = 2'd0;
            for (int w = 0; w < 4; w++) mdat[i][w] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        chk(line_state == 8'h00, "R1 reset states", 128'(line_state), 128'h0);
        chk(!bus_req, "R1 reset bus_req", 128'(bus_req), 128'h0);
        chk(cpu_ready, "R1 reset ready", 128'(cpu_ready), 128'h1);
        @(negedge clk);

        do_op(1'b0, 10'h000, 4'h0, 32'h0, 2);          // R7 load miss, shared -> S
        do_op(1'b1, 10'h001, 4'b0011, 32'hCAFE_BEEF, 0); // R5 kill then M, R10 partial
        do_op(1'b0, 10'h001, 4'h0, 32'h0, 0);          // R2 + R10 merged lanes
        do_op(1'b1, 10'h002, 4'b1000, 32'h1122_3344, 0); // R4 store on M
        do_op(1'b0, 10'h014, 4'h0, 32'h0, 1);          // R7 load miss, not shared -> E
        do_op(1'b1, 10'h015, 4'b1111, 32'hDEAD_0001, 0); // R3 store on E
        do_op(1'b1, 10'h02A, 4'b0100, 32'h00AB_0000, 0); // R6 store miss
        do_op(1'b0, 10'h02A, 4'h0, 32'h0, 0);          // R10 merged into fill
        do_op(1'b0, 10'h103, 4'h0, 32'h0, 1);          // R8 dirty victim write-back
        do_op(1'b0, 10'h00C, 4'h0, 32'h0, 1);          // idx3 clean install
        do_op(1'b0, 10'h04E, 4'h0, 32'h0, 2);          // R8 clean victim, no write-back
        do_op(1'b0, 10'h002, 4'h0, 32'h0, 0);          // data written back earlier reread

        for (int n = 0; n < 400; n++) begin
            logic [9:0] a;
            a = {6'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
            do_op(1'($urandom % 2), a, 4'($urandom_range(1, 15)), $urandom, 0);
        end

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule